// File: doc/BRIEF.md
# Single-Port Synchronous RAM with Selectable Read-During-Write Behaviour

This block is a parameterized on-chip memory of `DEPTH` words, each `WIDTH` bits wide, with one port that shares its address between reading and writing. On every rising clock edge the port takes an address, a write strobe and a write word. The word at that address is presented on a registered output one cycle later. A cycle with the strobe low is a plain read and leaves the contents untouched.

The same-cycle behaviour of the read output during a write is fixed at build time by a two-bit parameter. Value 0 (new-data mode, the default) returns the word being written. Value 1 (old-data mode) returns the word stored before the write. Value 2 (hold mode) keeps the output unchanged for that cycle. Value 3 stops elaboration. Every word starts at one two-state parameter value, so it cannot hold unknown bits. A synchronous active-high reset clears only the read register.

The address width is `clog2(DEPTH)` bits, with a minimum of 1. When `DEPTH` is not a power of two, some address codes fall outside the memory. Those codes never write and always read as zero.

Top module: `wm_sp_ram`

## Requirements
- R1: The address port is max(1, clog2(DEPTH)) bits wide. A one-word memory therefore has a 1-bit address, its only word sits at address 0, and address 1 does not alias onto it.
- R2: While `rst` is high at a clock edge, `rdata` becomes zero after that edge and no write takes effect. Memory contents survive the reset.
- R3: After an edge with `we` low and an in-range address, `rdata` equals the word stored at that address, and no stored word changes.
- R4: A write with `we` high captures `addr` and `wdata` at the clock edge. From the next cycle on, reads of that address return `wdata`, whatever the mode.
- R5: With WMODE = 0 (new-data), after an in-range write edge `rdata` equals the written `wdata`.
- R6: With WMODE = 1 (old-data), after an in-range write edge `rdata` equals the word that was stored at that address before the write.
- R7: With WMODE = 2 (hold), after an in-range write edge `rdata` keeps the value it had before that edge.
- R8: Every word holds `INIT_VAL` until it is first written.
- R9: An address at or above `DEPTH` never writes, and `rdata` becomes zero after such an edge in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | max(1, clog2(DEPTH)) | Shared read/write word address |
| we | input | 1 | Write strobe; high writes `wdata` at `addr` |
| wdata | input | WIDTH | Word to be written |
| rdata | output | WIDTH | Registered read word |

## Verification
Assertions check on every cycle the following behaviours:
- The mode-specific output after a write: the written word, the pre-write word, or a held value.
- The read-only path, which must return the word taken from storage in the previous cycle.
- The zero output for reset and for out-of-range addresses.
- That a written word appears in storage one edge later.

Only the bench scenarios can show the remaining behaviours:
- That words nobody wrote still carry the initial value.
- That contents survive a reset.
- That out-of-range writes do not corrupt any real word.
- That the one-word configuration behaves as specified.

The bench does this with full address sweeps and a long random mix, run against all three modes in parallel.

// File: rtl/wm_ram_pkg.sv
package wm_ram_pkg;

  // Read-during-write selection codes
  localparam logic [1:0] WM_NEW_DATA = 2'd0;
  localparam logic [1:0] WM_OLD_DATA = 2'd1;
  localparam logic [1:0] WM_HOLD     = 2'd2;

  // Address bits for a given depth, never fewer than one
  function automatic int addr_bits(input int depth);
    int bits;
    bits = 1;
    while ((1 << bits) < depth) bits++;
    return bits;
  endfunction

  // True when an address code names a real word
  function automatic bit in_range(input int unsigned a, input int depth);
    return a < depth;
  endfunction

endpackage

// File: rtl/wm_ram_gate.sv
module wm_ram_gate
  import wm_ram_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  output logic          addr_ok,
  output logic          wr_hit
);

  always_comb begin
    addr_ok = in_range(int'(unsigned'(addr)), DEPTH);
    wr_hit  = we && addr_ok && !rst;
  end

endmodule

// File: rtl/wm_ram_store.sv
module wm_ram_store #(
  parameter int            WIDTH    = 8,
  parameter int            AW       = 4,
  parameter bit [WIDTH-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] cur_word
);

  localparam int SLOTS = 1 << AW;

  logic [WIDTH-1:0] mem_q [SLOTS];

  initial begin
    for (int i = 0; i < SLOTS; i++) mem_q[i] = INIT_VAL;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[addr] <= wdata;
  end

  assign cur_word = mem_q[addr];

  // R4
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mem_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/wm_ram_rdreg.sv
module wm_ram_rdreg
  import wm_ram_pkg::*;
#(
  parameter int         WIDTH = 8,
  parameter logic [1:0] WMODE = WM_NEW_DATA
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_ok,
  input  logic             wr_hit,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] cur_word,
  output logic [WIDTH-1:0] rdata
);

  // Value the output register takes at the next edge
  function automatic logic [WIDTH-1:0] next_out(
    input logic [1:0]       mode,
    input logic             hit,
    input logic             ok,
    input logic [WIDTH-1:0] wd,
    input logic [WIDTH-1:0] stored,
    input logic [WIDTH-1:0] prev
  );
    logic [WIDTH-1:0] rd;
    rd = ok ? stored : '0;
    if (!hit) return rd;
    case (mode)
      WM_NEW_DATA: return wd;
      WM_OLD_DATA: return rd;
      default:     return prev;
    endcase
  endfunction

  logic [WIDTH-1:0] rd_next;

  always_comb rd_next = next_out(WMODE, wr_hit, addr_ok, wdata, cur_word, rdata);

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  // R2
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> rdata == '0);

  // R3
  plain_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr_ok && !wr_hit && !rst) |=> rdata == $past(cur_word));

  // R9
  out_of_range_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_ok && !rst) |=> rdata == '0);

  if (WMODE == WM_NEW_DATA) begin : g_new
    // R5
    new_data_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> rdata == $past(wdata));
  end else if (WMODE == WM_OLD_DATA) begin : g_old
    // R6
    old_data_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> rdata == $past(cur_word));
  end else begin : g_hold
    // R7
    hold_out_chk: assert property (@(posedge clk) disable iff (rst)
      wr_hit |=> $stable(rdata));
  end

endmodule

// File: rtl/wm_sp_ram.sv
module wm_sp_ram
  import wm_ram_pkg::*;
#(
  parameter int             WIDTH    = 8,
  parameter int             DEPTH    = 16,
  parameter logic [1:0]     WMODE    = WM_NEW_DATA,
  parameter bit [WIDTH-1:0] INIT_VAL = '0,
  localparam int            AW       = addr_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);

  if (WMODE > WM_HOLD) begin : g_bad_mode
    $fatal(1, "wm_sp_ram: write-mode code 3 is not defined");
  end
  if (DEPTH < 1) begin : g_bad_depth
    $fatal(1, "wm_sp_ram: depth must be at least one word");
  end

  logic             addr_ok;
  logic             wr_hit;
  logic [WIDTH-1:0] cur_word;

  wm_ram_gate #(.DEPTH(DEPTH), .AW(AW)) gate_i (
    .rst(rst), .we(we), .addr(addr), .addr_ok(addr_ok), .wr_hit(wr_hit)
  );

  wm_ram_store #(.WIDTH(WIDTH), .AW(AW), .INIT_VAL(INIT_VAL)) store_i (
    .clk(clk), .rst(rst), .wr_en(wr_hit), .addr(addr), .wdata(wdata),
    .cur_word(cur_word)
  );

  wm_ram_rdreg #(.WIDTH(WIDTH), .WMODE(WMODE)) rdreg_i (
    .clk(clk), .rst(rst), .addr_ok(addr_ok), .wr_hit(wr_hit), .wdata(wdata),
    .cur_word(cur_word), .rdata(rdata)
  );

endmodule

// File: tb/wm_sp_ram_tb.sv
module wm_sp_ram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W     = 8;
  localparam int DEPTH = 12;
  localparam int AW    = 4;
  localparam logic [W-1:0] INIT = 8'hA5;
  localparam logic [W-1:0] INIT1 = 8'h3C;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          rst_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic          we_i = 1'b0;
  logic [W-1:0]  wd_i = '0;
  logic [W-1:0]  rd_o [3];

  logic          o_addr = 1'b0;
  logic          o_we = 1'b0;
  logic [W-1:0]  o_wd = '0;
  logic [W-1:0]  o_rd;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    wm_sp_ram #(.WIDTH(W), .DEPTH(DEPTH), .WMODE(2'(m)), .INIT_VAL(INIT)) dut_i (
      .clk(clk), .rst(rst_i), .addr(addr_i), .we(we_i), .wdata(wd_i),
      .rdata(rd_o[m])
    );
  end

  if (1) begin : g_one
    wm_sp_ram #(.WIDTH(W), .DEPTH(1), .WMODE(2'd0), .INIT_VAL(INIT1)) dut_i (
      .clk(clk), .rst(rst_i), .addr(o_addr), .we(o_we), .wdata(o_wd),
      .rdata(o_rd)
    );
  end

  int n_cmp = 0;
  int n_bad = 0;
  logic [W-1:0] ref_mem [16];
  logic [W-1:0] prev [3];

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One clocked access applied to all three mode variants
  task automatic step(input logic r, input logic [AW-1:0] a, input logic w,
                      input logic [W-1:0] d, input string note);
    logic [W-1:0] exp [3];
    logic ok, hit;
    logic [W-1:0] old;
    string tag;
    ok  = int'(a) < DEPTH;
    hit = w && ok && !r;
    old = ok ? ref_mem[a] : '0;
    exp[0] = hit ? d : old;
    exp[1] = old;
    exp[2] = hit ? prev[2] : old;
    if (r) for (int m = 0; m < 3; m++) exp[m] = '0;
    rst_i = r; addr_i = a; we_i = w; wd_i = d;
    @(posedge clk);
    @(negedge clk);
    for (int m = 0; m < 3; m++) begin
      if (note != "") tag = note;
      else if (r) tag = "R2";
      else if (!ok) tag = "R9";
      else if (hit) tag = (m == 0) ? "R5" : (m == 1) ? "R6" : "R7";
      else tag = "R3";
      check($sformatf("%s mode%0d", tag, m), rd_o[m], exp[m]);
      prev[m] = exp[m];
    end
    if (hit) ref_mem[a] = d;
  endtask

  task automatic step1(input logic a, input logic w, input logic [W-1:0] d,
                       input logic [W-1:0] exp, input string tag);
    o_addr = a; o_we = w; o_wd = d;
    @(posedge clk);
    @(negedge clk);
    check($sformatf("%s depth1", tag), o_rd, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got %0d expected 0 pending", 1);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    for (int i = 0; i < 16; i++) ref_mem[i] = (i < DEPTH) ? INIT : '0;
    for (int m = 0; m < 3; m++) prev[m] = '0;
    @(negedge clk);
    // R2: reset state of the read register
    step(1'b1, '0, 1'b0, '0, "R2");
    step(1'b1, 4'd3, 1'b1, 8'h77, "R2");   // write under reset ignored
    // R8 and R9: sweep every code before any write
    for (int a = 0; a < 16; a++) step(1'b0, 4'(a), 1'b0, '0, (a < DEPTH) ? "R8" : "R9");
    // R5, R6, R7: write each word once
    for (int a = 0; a < DEPTH; a++) step(1'b0, 4'(a), 1'b1, 8'(a * 37 + 11), "");
    // R4: read back every word
    for (int a = 0; a < DEPTH; a++) step(1'b0, 4'(a), 1'b0, 8'hFF, "R4");
    // Back-to-back writes to one word, then reads
    step(1'b0, 4'd5, 1'b1, 8'h11, "");
    step(1'b0, 4'd5, 1'b1, 8'h22, "");
    step(1'b0, 4'd5, 1'b1, 8'h33, "");
    step(1'b0, 4'd5, 1'b0, 8'h44, "R4");
    step(1'b0, 4'd5, 1'b0, 8'h55, "R3");
    // R9: out-of-range writes must not alias
    for (int a = DEPTH; a < 16; a++) step(1'b0, 4'(a), 1'b1, 8'hEE, "R9");
    for (int a = 0; a < DEPTH; a++) step(1'b0, 4'(a), 1'b0, '0, "R9");
    // R2: reset mid-run keeps contents
    step(1'b1, 4'd2, 1'b0, '0, "R2");
    step(1'b0, 4'd2, 1'b0, '0, "R2");
    // Random mix
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[11:5] == 7'd0, lfsr[3:0], lfsr[4], lfsr[15:8], "");
    end
    // R1: one-word memory
    we_i = 1'b0; rst_i = 1'b0;
    step1(1'b0, 1'b0, 8'h00, INIT1, "R8");
    step1(1'b0, 1'b1, 8'h5A, 8'h5A, "R5");
    step1(1'b1, 1'b1, 8'hFF, 8'h00, "R1");
    step1(1'b0, 1'b0, 8'h00, 8'h5A, "R1");
    finish_run();
  end

endmodule